// File: doc/BRIEF.md
# Flagless Integer ALU with Immediate Forms

This block is the purely combinational execute stage of a 32-bit integer datapath. Each operation reads two register operands and, for immediate forms, a 16-bit or 5-bit immediate carried in the instruction. It returns a 32-bit result and a single branch-taken bit. The ALU keeps no condition flags, so carry and overflow never leave the block; software tests for them with compare operations.

The immediate is extended in one of three ways, chosen by the operation. Arithmetic, equality and signed-compare forms sign-extend it. Logic and unsigned-compare forms zero-extend it. The high forms place it in the upper half of the word and fill the lower half with zeros. Shift and rotate amounts come either from the 5-bit immediate or from the five low bits of the second register operand. Branch operations only evaluate their condition. The next-address arithmetic is done elsewhere.

Top module: `flagless_alu`

## Requirements
- R1: `op_sel` encodes the operations as follows: 0 add, 1 add-imm, 2 sub, 3 and, 4 or, 5 xor, 6 nor, 7 and-imm, 8 or-imm, 9 xor-imm, 10 nor-imm, 11 and-high, 12 or-high, 13 xor-high, 14 eq, 15 ne, 16 lt-signed, 17 ge-signed, 18 lt-unsigned, 19 ge-unsigned, 20 to 25 the immediate forms of codes 14 to 19 in the same order, 26 shl, 27 shr-logical, 28 shr-arith, 29 rotr, 30 rotl, 31 shl-imm, 32 shr-logical-imm, 33 shr-arith-imm, 34 rotl-imm, 35 br-eq, 36 br-ne, 37 br-lt, 38 br-ge, 39 br-ltu, 40 br-geu. Codes 41 to 63 give `result` = 0 and `take_branch` = 0.
- R2: add and sub wrap modulo 2^32 and set no flag. The add-imm form adds the 16-bit immediate sign-extended to 32 bits.
- R3: The register forms of and, or, xor and nor work bitwise on `op_a` and `op_b`.
- R4: The and, or, xor and nor immediate forms zero-extend the 16-bit immediate to 32 bits before the operation. This holds for nor as well.
- R5: The high forms use `imm16` as bits 31:16 of the second operand and zeros as bits 15:0.
- R6: The register compares write 1 to `result` when the condition holds and 0 otherwise. Bits 31:1 of `result` are always zero.
- R7: The immediate compares eq, ne, lt-signed and ge-signed sign-extend `imm16`. lt-unsigned and ge-unsigned zero-extend it.
- R8: The register forms of shift and rotate use only `op_b[4:0]` as the amount. The immediate forms use `imm5`.
- R9: shr-logical fills the vacated bits with zeros. shr-arith fills them with copies of `op_a[31]`. shl fills with zeros.
- R10: rotr moves bits toward bit 0 and wraps bit 0 into bit 31. rotl and rotl-imm move bits toward bit 31 and wrap bit 31 into bit 0.
- R11: Any shift or rotate with an amount of 0 returns `op_a` unchanged.
- R12: For the branch codes, `take_branch` follows the condition on `op_a` and `op_b` (eq, ne, signed lt, signed ge, unsigned lt, unsigned ge) and `result` is 0. For every other code `take_branch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 6 | Operation code (encoding in R1) |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| imm16 | input | 16 | Instruction immediate |
| imm5 | input | 5 | Immediate shift or rotate amount |
| result | output | 32 | Operation result |
| take_branch | output | 1 | Branch condition is true |

## Verification
Both outputs are combinational, so each result is due in the same cycle its inputs are applied, with no register in the path. The bench changes the inputs just after a rising clock edge. It samples `result` and `take_branch` at the following falling edge, half a period later, when everything has settled. The next stimulus is applied only after that sample, so one check always sees exactly one input set.

// File: rtl/flagless_alu.sv
module flagless_alu (
  input  logic [5:0]  op_sel,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [15:0] imm16,
  input  logic [4:0]  imm5,
  output logic [31:0] result,
  output logic        take_branch
);
  localparam logic [5:0] ADD = 0, ADDI = 1, SUB = 2, AND_ = 3, OR_ = 4, XOR_ = 5, NOR_ = 6;
  localparam logic [5:0] ANDI = 7, ORI = 8, XORI = 9, NORI = 10, ANDH = 11, ORH = 12, XORH = 13;
  localparam logic [5:0] CEQ = 14, CNE = 15, CLT = 16, CGE = 17, CLTU = 18, CGEU = 19;
  localparam logic [5:0] CEQI = 20, CNEI = 21, CLTI = 22, CGEI = 23, CLTUI = 24, CGEUI = 25;
  localparam logic [5:0] SHL = 26, SHR = 27, SRA_ = 28, ROTR = 29, ROTL = 30;
  localparam logic [5:0] SHLI = 31, SHRI = 32, SRAI = 33, ROTLI = 34;
  localparam logic [5:0] BEQ = 35, BNE = 36, BLT = 37, BGE = 38, BLTU = 39, BGEU = 40;

  wire [31:0] imm_sx = {{16{imm16[15]}}, imm16};
  wire [31:0] imm_zx = {16'h0000, imm16};
  wire [31:0] imm_hi = {imm16, 16'h0000};

  logic [31:0] opnd;
  always_comb begin
    unique case (op_sel)
      ADDI, CEQI, CNEI, CLTI, CGEI:     opnd = imm_sx;
      ANDI, ORI, XORI, NORI, CLTUI, CGEUI: opnd = imm_zx;
      ANDH, ORH, XORH:                  opnd = imm_hi;
      default:                          opnd = op_b;
    endcase
  end

  wire        imm_amt = (op_sel == SHLI) || (op_sel == SHRI) || (op_sel == SRAI) || (op_sel == ROTLI);
  wire [4:0]  shamt   = imm_amt ? imm5 : op_b[4:0];
  wire [5:0]  wrap    = 6'd32 - {1'b0, shamt};
  wire [31:0] rot_r   = (op_a >> shamt) | (op_a << wrap);
  wire [31:0] rot_l   = (op_a << shamt) | (op_a >> wrap);
  wire [31:0] sra_v   = $signed(op_a) >>> shamt;

  wire is_eq = (op_a == opnd);
  wire lt_s  = ($signed(op_a) < $signed(opnd));
  wire lt_u  = (op_a < opnd);

  always_comb begin
    result = '0;
    unique case (op_sel)
      ADD, ADDI:               result = op_a + opnd;
      SUB:                     result = op_a - opnd;
      AND_, ANDI, ANDH:        result = op_a & opnd;
      OR_, ORI, ORH:           result = op_a | opnd;
      XOR_, XORI, XORH:        result = op_a ^ opnd;
      NOR_, NORI:              result = ~(op_a | opnd);
      CEQ, CEQI:               result = {31'd0, is_eq};
      CNE, CNEI:               result = {31'd0, !is_eq};
      CLT, CLTI:               result = {31'd0, lt_s};
      CGE, CGEI:               result = {31'd0, !lt_s};
      CLTU, CLTUI:             result = {31'd0, lt_u};
      CGEU, CGEUI:             result = {31'd0, !lt_u};
      SHL, SHLI:               result = op_a << shamt;
      SHR, SHRI:               result = op_a >> shamt;
      SRA_, SRAI:              result = sra_v;
      ROTR:                    result = rot_r;
      ROTL, ROTLI:             result = rot_l;
      default:                 result = '0;
    endcase
  end

  always_comb begin
    unique case (op_sel)
      BEQ:     take_branch = is_eq;
      BNE:     take_branch = !is_eq;
      BLT:     take_branch = lt_s;
      BGE:     take_branch = !lt_s;
      BLTU:    take_branch = lt_u;
      BGEU:    take_branch = !lt_u;
      default: take_branch = 1'b0;
    endcase
  end
endmodule

module flagless_alu_chk (
  input logic [5:0]  op_sel,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [15:0] imm16,
  input logic [4:0]  imm5,
  input logic [31:0] result,
  input logic        take_branch
);
  always_comb begin
    if (op_sel == 6'd0)
      assert_add_wraps_R2: assert (result - op_b == op_a);
    if (op_sel == 6'd11)
      assert_andhi_low_zero_R5: assert (result == {op_a[31:16] & imm16, 16'h0000});
    if (op_sel == 6'd12 || op_sel == 6'd13)
      assert_hi_keeps_low_R5: assert (result[15:0] == op_a[15:0]);
    if (op_sel >= 6'd14 && op_sel <= 6'd25)
      assert_cmp_is_bool_R6: assert (result[31:1] == 31'd0);
    if ((op_sel == 6'd27 || op_sel == 6'd32) && result != op_a)
      assert_srl_zero_fill_R9: assert (result[31] == 1'b0);
    if (op_sel == 6'd28 || op_sel == 6'd33)
      assert_sra_sign_R9: assert (result[31] == op_a[31]);
    if ((op_sel >= 6'd26 && op_sel <= 6'd30 && op_b[4:0] == 5'd0) ||
        (op_sel >= 6'd31 && op_sel <= 6'd34 && imm5 == 5'd0))
      assert_zero_amount_R11: assert (result == op_a);
    if (op_sel >= 6'd35 && op_sel <= 6'd40)
      assert_branch_result_zero_R12: assert (result == 32'd0);
    else
      assert_no_branch_R12: assert (!take_branch);
    if (op_sel >= 6'd41)
      assert_unused_code_R1: assert (result == 32'd0 && !take_branch);
  end
endmodule

bind flagless_alu flagless_alu_chk u_chk (
  .op_sel(op_sel), .op_a(op_a), .op_b(op_b), .imm16(imm16), .imm5(imm5),
  .result(result), .take_branch(take_branch)
);

// File: tb/test_flagless_alu.sv
module test_flagless_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_sel = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  imm5 = '0;
  logic [31:0] result;
  logic        take_branch;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flagless_alu i_flagless_alu (
    .op_sel(op_sel), .op_a(op_a), .op_b(op_b), .imm16(imm16), .imm5(imm5),
    .result(result), .take_branch(take_branch)
  );

  function automatic logic [31:0] rotr_m(input logic [31:0] v, input int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic logic [32:0] model(input int op, input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] i16, input logic [4:0] i5);
    logic [31:0] sx = {{16{i16[15]}}, i16};
    logic [31:0] zx = {16'h0, i16};
    logic [31:0] hi = {i16, 16'h0};
    int rn = int'(b[4:0]);
    int im = int'(i5);
    logic [31:0] r = 0;
    logic br = 0;
    case (op)
      0: r = a + b;  1: r = a + sx;  2: r = a - b;
      3: r = a & b;  4: r = a | b;   5: r = a ^ b;  6: r = ~(a | b);
      7: r = a & zx; 8: r = a | zx;  9: r = a ^ zx; 10: r = ~(a | zx);
      11: r = a & hi; 12: r = a | hi; 13: r = a ^ hi;
      14: r = 32'(a == b); 15: r = 32'(a != b);
      16: r = 32'($signed(a) < $signed(b)); 17: r = 32'($signed(a) >= $signed(b));
      18: r = 32'(a < b); 19: r = 32'(a >= b);
      20: r = 32'(a == sx); 21: r = 32'(a != sx);
      22: r = 32'($signed(a) < $signed(sx)); 23: r = 32'($signed(a) >= $signed(sx));
      24: r = 32'(a < zx); 25: r = 32'(a >= zx);
      26: r = a << rn; 27: r = a >> rn; 28: r = 32'($signed(a) >>> rn);
      29: r = rotr_m(a, rn); 30: r = rotr_m(a, (32 - rn) % 32);
      31: r = a << im; 32: r = a >> im; 33: r = 32'($signed(a) >>> im);
      34: r = rotr_m(a, (32 - im) % 32);
      35: br = (a == b); 36: br = (a != b);
      37: br = ($signed(a) < $signed(b)); 38: br = ($signed(a) >= $signed(b));
      39: br = (a < b); 40: br = (a >= b);
      default: begin r = 0; br = 0; end
    endcase
    return {br, r};
  endfunction

  function automatic string req_of(input int op);
    if (op <= 2) return "R2";
    if (op <= 6) return "R3";
    if (op <= 10) return "R4";
    if (op <= 13) return "R5";
    if (op <= 19) return "R6";
    if (op <= 25) return "R7";
    if (op == 29 || op == 30 || op == 34) return "R10";
    if (op <= 34) return "R9";
    if (op <= 40) return "R12";
    return "R1";
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i16, input logic [4:0] i5);
    @(posedge clk);
    #1;
    op_sel = 6'(op); op_a = a; op_b = b; imm16 = i16; imm5 = i5;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [32:0] exp);
    checks++;
    if ({take_branch, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d actual br=%0b res=%h expected br=%0b res=%h",
               req, op_sel, take_branch, result, exp[32], exp[31:0]);
    end
  endtask

  task automatic dir(input string req, input int op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] i16, input logic [4:0] i5, input logic [32:0] exp);
    apply(op, a, b, i16, i5);
    check(req, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 33'h0);
    dir("R1 unused code", 41, 32'hFFFF_FFFF, 32'h1234, 16'hFFFF, 5'd3, 33'h0);
    dir("R1 unused code", 63, 32'h5, 32'h5, 16'h0, 5'd0, 33'h0);
    dir("R2 add wrap", 0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 33'h0);
    dir("R2 sub wrap", 2, 32'h0, 32'h1, 16'h0, 5'd0, {1'b0, 32'hFFFF_FFFF});
    dir("R2 addi sign", 1, 32'd10, 32'h0, 16'hFFFF, 5'd0, {1'b0, 32'd9});
    dir("R3 nor", 6, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 5'd0, {1'b0, 32'h0F0F_F0F0});
    dir("R4 nori zero-ext", 10, 32'h0, 32'h0, 16'h00FF, 5'd0, {1'b0, 32'hFFFF_FF00});
    dir("R4 andi zero-ext", 7, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, {1'b0, 32'h0000_8000});
    dir("R5 orhi", 12, 32'h0000_1234, 32'h0, 16'hABCD, 5'd0, {1'b0, 32'hABCD_1234});
    dir("R5 andhi", 11, 32'hFFFF_FFFF, 32'h0, 16'h0F0F, 5'd0, {1'b0, 32'h0F0F_0000});
    dir("R6 lt signed", 16, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, {1'b0, 32'd1});
    dir("R6 lt unsigned", 18, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 33'h0);
    dir("R7 lti sign-ext", 22, 32'h0, 32'h0, 16'h8000, 5'd0, 33'h0);
    dir("R7 ltui zero-ext", 24, 32'h0, 32'h0, 16'h8000, 5'd0, {1'b0, 32'd1});
    dir("R8 low five bits", 27, 32'h8000_0000, 32'h21, 16'h0, 5'd0, {1'b0, 32'h4000_0000});
    dir("R9 sra fill", 28, 32'h8000_0000, 32'd4, 16'h0, 5'd0, {1'b0, 32'hF800_0000});
    dir("R9 srli fill", 32, 32'h8000_0000, 32'd0, 16'h0, 5'd4, {1'b0, 32'h0800_0000});
    dir("R10 rotr", 29, 32'h1, 32'd1, 16'h0, 5'd0, {1'b0, 32'h8000_0000});
    dir("R10 rotl", 30, 32'h8000_0000, 32'd1, 16'h0, 5'd0, {1'b0, 32'h1});
    dir("R10 rotli", 34, 32'hF000_0000, 32'd0, 16'h0, 5'd4, {1'b0, 32'h0000_000F});
    dir("R11 shl by 32", 26, 32'hDEAD_BEEF, 32'd32, 16'h0, 5'd0, {1'b0, 32'hDEAD_BEEF});
    dir("R11 rotli by 0", 34, 32'hDEAD_BEEF, 32'd7, 16'h0, 5'd0, {1'b0, 32'hDEAD_BEEF});
    dir("R12 blt", 37, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0, {1'b1, 32'h0});
    dir("R12 bltu", 39, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0, 33'h0);
    dir("R12 beq", 35, 32'h77, 32'h77, 16'h0, 5'd0, {1'b1, 32'h0});
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 47));
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [15:0] i16 = 16'($urandom);
      logic [4:0] i5 = 5'($urandom);
      case ($urandom_range(0, 7))
        0: b = a;
        1: a = 32'h8000_0000;
        2: b = 32'hFFFF_FFFF;
        3: begin b = b & 32'h1F; i5 = 5'd0; end
        default: ;
      endcase
      apply(op, a, b, i16, i5);
      check(req_of(op), model(op, a, b, i16, i5));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule